// File: doc/BRIEF.md
# ARINC 429 Word Transmitter

This block turns one 32-bit avionics data word into a bipolar return-to-zero bit stream. The stream is shown as two digital lines: a mark-one line and a mark-zero line. A host writes the word into a holding register through a 16-bit parallel bus. The low half holds line bits 1 to 16 and the high half holds line bits 17 to 32. The host then pulses a start input. The block captures the held word and sends it with line bit 1 first. It drives each bit for the first half of its bit period and leaves both lines low for the second half. After the last bit it keeps the line null for four more bit times before it will accept another word.

Control inputs are sampled when a transmission starts:
- A divider select picks a bit period of 10 or 80 master clocks.
- A parity enable lets the block replace bit 32 with a parity bit that it computes.
- A sense input picks odd or even parity.

A loopback input feeds the transmitter lines into the receiver-side outputs in place of the external line inputs, so a host can self-test the receive path.

Top module: `a429_word_tx`

## Requirements
- R1: After reset, both line outputs and busy are low.
- R2: A start pulse seen while idle makes busy high from the next clock edge. Busy then stays high for exactly 36 bit periods: 32 data bits and 4 gap bits.
- R3: The word sent is the held word captured at the start edge. Bus transfers with ld_lo write bits 15:0 and transfers with ld_hi write bits 31:16. Word bit 0 (line bit 1) is sent first and bit 31 (line bit 32) is sent last.
- R4: In every data bit period, the first half of the period drives tx_one (bit is 1) or tx_zero (bit is 0). The second half is null. The two outputs are never high together.
- R5: With div_slow=0 a bit period is 10 clocks and with div_slow=1 it is 80 clocks. The value is sampled at start.
- R6: With par_en=0, bit 32 is sent exactly as loaded.
- R7: With par_en=1, bit 32 is replaced by a parity bit. If par_even=0, the 32 bits sent hold an odd number of ones. If par_even=1, they hold an even number of ones.
- R8: During the 4 gap bit periods, both line outputs stay low.
- R9: A start while busy is ignored: the word in flight and the busy length do not change. Loads while busy update only the holding register, which is used by the next start.
- R10: With loop_en=1, rx_one and rx_zero follow tx_one and tx_zero. With loop_en=0, they follow line_one and line_zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_data | input | 16 | Host data bus |
| ld_lo | input | 1 | Write bus into word bits 15:0 |
| ld_hi | input | 1 | Write bus into word bits 31:16 |
| start | input | 1 | Request transmission of the held word |
| div_slow | input | 1 | 0: bit period 10 clocks, 1: 80 clocks |
| par_en | input | 1 | Insert computed parity in bit 32 |
| par_even | input | 1 | 0: odd parity, 1: even parity |
| loop_en | input | 1 | Route transmitter lines to receive outputs |
| line_one | input | 1 | External receive mark-one line |
| line_zero | input | 1 | External receive mark-zero line |
| tx_one | output | 1 | Transmit mark-one line |
| tx_zero | output | 1 | Transmit mark-zero line |
| rx_one | output | 1 | Receive-side mark-one input |
| rx_zero | output | 1 | Receive-side mark-zero input |
| busy | output | 1 | Transmission or gap in progress |

## Verification
The output state during cycle t after the start edge is the state after that edge. This is the state before the next edge, with t counted from 0.
- Bit k is due at t = k·P, where P is the bit period.
- Its mark lasts P/2 cycles.
- Busy falls at t = 36·P.

The bench samples on the falling edge. It compares every cycle of every word with a model indexed by t, so an off-by-one in the divider or the bit index fails at once. The receive outputs are combinational, so they are checked in the same cycle as the line inputs that drive them.

// File: rtl/a429_word_tx.sv
module a429_word_tx #(
  parameter int DATA_W   = 16,
  parameter int DIV_FAST = 10,
  parameter int DIV_SLOW = 80,
  parameter int GAP_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic              start,
  input  logic              div_slow,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              loop_en,
  input  logic              line_one,
  input  logic              line_zero,
  output logic              tx_one,
  output logic              tx_zero,
  output logic              rx_one,
  output logic              rx_zero,
  output logic              busy
);
  localparam int WORD_W = 2 * DATA_W;
  localparam int TOTAL  = WORD_W + GAP_BITS;
  localparam int CNT_W  = $clog2(DIV_SLOW);
  localparam int IDX_W  = $clog2(TOTAL + 1);
  localparam int SEL_W  = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_F = CNT_W'(DIV_FAST - 1);
  localparam logic [CNT_W-1:0] LAST_S = CNT_W'(DIV_SLOW - 1);
  localparam logic [CNT_W-1:0] HALF_F = CNT_W'(DIV_FAST / 2);
  localparam logic [CNT_W-1:0] HALF_S = CNT_W'(DIV_SLOW / 2);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(WORD_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(TOTAL - 1);

  logic [WORD_W-1:0] hold_q, word_q, next_word;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic              busy_q, slow_q, par_bit, in_data, mark, period_end;

  assign par_bit   = par_even ? ^hold_q[WORD_W-2:0] : ~^hold_q[WORD_W-2:0];
  assign next_word = {par_en ? par_bit : hold_q[WORD_W-1], hold_q[WORD_W-2:0]};

  assign period_end = cnt_q == (slow_q ? LAST_S : LAST_F);
  assign in_data    = idx_q < IDX_DATA;
  assign mark       = busy_q && in_data && (cnt_q < (slow_q ? HALF_S : HALF_F));

  assign tx_one  = mark &&  word_q[idx_q[SEL_W-1:0]];
  assign tx_zero = mark && !word_q[idx_q[SEL_W-1:0]];
  assign rx_one  = loop_en ? tx_one  : line_one;
  assign rx_zero = loop_en ? tx_zero : line_zero;
  assign busy    = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= '0;
    else begin
      if (ld_lo) hold_q[DATA_W-1:0]      <= bus_data;
      if (ld_hi) hold_q[WORD_W-1:DATA_W] <= bus_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      slow_q <= 1'b0;
      word_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        slow_q <= div_slow;
        word_q <= next_word;
        cnt_q  <= '0;
        idx_q  <= '0;
      end
    end else if (period_end) begin
      cnt_q <= '0;
      if (idx_q == IDX_LAST) busy_q <= 1'b0;
      else idx_q <= idx_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r4_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_one && tx_zero));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_one && !tx_zero);
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !tx_zero == word_q[0]);
  a_r8_gap_null: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !in_data |-> !tx_one && !tx_zero);
  a_r9_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(word_q));
  a_r7_odd: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && par_en && !par_even |=> ^word_q);
  a_r7_even: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && par_en && par_even |=> !(^word_q));
  a_r6_as_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !par_en |=> word_q == $past(hold_q));
endmodule

// File: tb/test_a429_word_tx.sv
module test_a429_word_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] bus_data = '0;
  logic ld_lo = 0, ld_hi = 0, start = 0, div_slow = 0, par_en = 0, par_even = 0;
  logic loop_en = 0, line_one = 0, line_zero = 0;
  logic tx_one, tx_zero, rx_one, rx_zero, busy;
  int checks = 0, errors = 0;
  logic [31:0] hold_m = '0;
  bit done = 0;

  always #2 clk = ~clk;

  a429_word_tx i_a429_word_tx (.*);

  function automatic logic [31:0] exp_word(logic [31:0] w, logic pe, logic ev);
    int ones = $countones(w[30:0]);
    if (pe) w[31] = ev ? logic'(ones % 2) : logic'(1 - ones % 2);
    return w;
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load(logic [31:0] w);
    @(negedge clk); bus_data = w[15:0];  ld_lo = 1;
    @(negedge clk); ld_lo = 0; bus_data = w[31:16]; ld_hi = 1;
    @(negedge clk); ld_hi = 0;
    hold_m = w;
  endtask

  task automatic send(logic slow, logic pe, logic ev, logic lp, int inj);
    int per = slow ? 80 : 10;
    logic [31:0] w = exp_word(hold_m, pe, ev);
    logic [15:0] nlo = 16'($urandom);
    @(negedge clk);
    div_slow = slow; par_en = pe; par_even = ev; loop_en = lp; start = 1;
    @(negedge clk);
    start = 0;
    for (int t = 0; t <= 36 * per; t++) begin
      int b = t / per;
      logic mk = (t < 32 * per) && ((t % per) < per / 2);
      logic e1 = mk && w[b % 32];
      logic e0 = mk && !w[b % 32];
      string tg = (t >= 32 * per) ? "R8" : (b == 31) ? (pe ? "R7" : "R6") :
                  slow ? "R5" : (t % per >= per / 2) ? "R4" : "R3";
      chk(tg, {tx_one, tx_zero, 2'b00}, {e1, e0, 2'b00});
      chk(inj >= 0 ? "R9" : "R2", {busy, 3'b000}, {logic'(t < 36 * per), 3'b000});
      chk("R10", {rx_one, rx_zero, 2'b00},
          lp ? {e1, e0, 2'b00} : {line_one, line_zero, 2'b00});
      line_one = 1'($urandom); line_zero = 1'($urandom);
      start = (t == inj);
      ld_lo = (t == inj); bus_data = nlo;
      if (t == inj) hold_m[15:0] = nlo;
      @(negedge clk);
      start = 0; ld_lo = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4291));
    repeat (3) @(negedge clk);
    chk("R1", {tx_one, tx_zero, busy, 1'b0}, 4'b0000);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {tx_one, tx_zero, busy, 1'b0}, 4'b0000);
    load(32'h8000_0001); send(0, 0, 0, 1, -1);
    load(32'h0000_0000); send(0, 1, 0, 1, -1);
    load(32'h0000_0000); send(0, 1, 1, 0, -1);
    load(32'hFFFF_FFFF); send(0, 1, 0, 1, -1);
    load(32'h7FFF_FFFF); send(0, 0, 1, 1, -1);
    load(32'hA5C3_0F96); send(1, 1, 0, 1, -1);
    load(32'h1234_5678); send(0, 0, 0, 1, 57);
    send(0, 0, 0, 1, -1);
    load(32'hDEAD_BEEF); send(1, 0, 0, 1, 700);
    send(0, 1, 1, 1, 359);
    for (int n = 0; n < 30; n++) begin
      load($urandom);
      send(($urandom % 8) == 0, 1'($urandom), 1'($urandom), ($urandom % 4) != 0,
           ($urandom % 3 == 0) ? int'($urandom % 350) : -1);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule